// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block gathers the four interrupt sources of a synchronous serial port and presents them to software through four word registers on a simple register bus. Two sources are levels that come from the FIFOs: the transmit FIFO is at half fill or below, and the receive FIFO is at half fill or above. The other two are single-cycle event pulses: receive timeout and receive overrun.

The level sources are registered once and follow their inputs. They cannot be cleared, because they simply track the FIFO fill condition. The event sources are latched and stay set until software writes a one to the matching bit of the clear register.

A per-source enable mask, set to 1 to allow a source, gates the raw status into a masked status. The OR of the masked bits drives a single interrupt line to the interrupt controller.

Top module: `sirq_status_unit`

## Requirements
- R1: The enable mask register (`bus_addr` 0) is read/write and resets to 0000. In all four registers, bit 3 is transmit, bit 2 is receive, bit 1 is receive timeout and bit 0 is receive overrun.
- R2: After reset, the raw status (`bus_addr` 1) reads 1000: only the transmit bit is set.
- R3: The raw transmit and receive bits equal `tx_level` and `rx_level` as sampled at the previous clock edge. They are never latched.
- R4: A one-cycle pulse on `rx_timeout_pulse` or `rx_overrun_pulse` sets raw bit 1 or raw bit 0, and the bit stays set until it is cleared.
- R5: A write to the clear register (`bus_addr` 3) clears raw bit 1 and raw bit 0 where the written bit is 1. Written 0 bits have no effect. Written bits 3 and 2 have no effect.
- R6: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: The masked status (`bus_addr` 2) reads as the raw status ANDed with the mask.
- R8: `irq` is high exactly when at least one masked status bit is 1.
- R9: Writes to the raw status and to the masked status change neither the mask nor the raw status.
- R10: The clear register reads as zero, and read bits above bit 3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word select: 0 mask, 1 raw, 2 masked, 3 clear |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 4 | Write data, one bit per source |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| tx_level | input | 1 | Transmit FIFO at or below half fill |
| rx_level | input | 1 | Receive FIFO at or above half fill |
| rx_timeout_pulse | input | 1 | Receive timeout event, one cycle |
| rx_overrun_pulse | input | 1 | Receive overrun event, one cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with `DATA_W` left at 32. This puts 28 read bits above the source field within reach, so the zero upper bits of every register read are checked on each vector. The width leaves the collision between an event and its clear unchanged, as well as the asymmetry between the clearable event bits and the uncleared level bits. Both are driven directly at the bus, and each is observed through a register read on the following cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NSRC = 4;

    // Bit positions shared by all four registers
    localparam int SRC_TX  = 3;
    localparam int SRC_RX  = 2;
    localparam int SRC_TMO = 1;
    localparam int SRC_OVR = 0;

    // Event-type sources occupy the low bits
    localparam int NEVT = 2;

    typedef enum logic [1:0] {
        REG_MASK     = 2'd0,
        REG_RAW      = 2'd1,
        REG_MSK_STAT = 2'd2,
        REG_CLEAR    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic tmo;
        logic ovr;
    } src_vec_t;

    localparam src_vec_t RAW_RESET = '{tx: 1'b1, rx: 1'b0, tmo: 1'b0, ovr: 1'b0};

    function automatic logic [NSRC-1:0] gate_sources(input logic [NSRC-1:0] raw,
                                                     input logic [NSRC-1:0] en);
        return raw & en;
    endfunction

endpackage

// File: rtl/sirq_level_stage.sv
module sirq_level_stage #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= RST_VAL;
        else     q_o <= lvl_i;
    end

    // R3: level bit tracks its input one edge later
    a_r3_level_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_o == $past(lvl_i)));
endmodule

// File: rtl/sirq_event_latch.sv
module sirq_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)          q_o <= 1'b0;
        else if (pulse_i) q_o <= 1'b1;
        else if (clr_i)   q_o <= 1'b0;
    end

    a_r4_event_sticky: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        pulse_i |=> q_o);
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !pulse_i) |=> !q_o);
endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg
    import sirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst)        mask_o <= '0;
        else if (wr_en) mask_o <= wdata;
    end

    a_r1_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask_o == $past(wdata)));
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/sirq_readback.sv
module sirq_readback
    import sirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   mask,
    output logic [DATA_W-1:0] rdata
);
    logic [NSRC-1:0] field;

    always_comb begin
        unique case (reg_sel_e'(sel))
            REG_MASK:     field = mask;
            REG_RAW:      field = raw;
            REG_MSK_STAT: field = gate_sources(raw, mask);
            default:      field = '0;
        endcase
        rdata             = '0;
        rdata[NSRC-1:0]   = field;
    end

    a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_CLEAR) |-> (rdata == '0));
    a_r7_masked_within_mask: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_MSK_STAT) |-> ((rdata[NSRC-1:0] & ~mask) == '0));
endmodule

// File: rtl/sirq_status_unit.sv
module sirq_status_unit
    import sirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_level,
    input  logic              rx_level,
    input  logic              rx_timeout_pulse,
    input  logic              rx_overrun_pulse,
    output logic              irq
);
    localparam logic [NSRC-1:0] RST_BITS = RAW_RESET;

    logic [NSRC-1:0] src_in;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] mask_q;
    logic            mask_wr;
    logic            clr_wr;

    always_comb begin
        src_in          = '0;
        src_in[SRC_TX]  = tx_level;
        src_in[SRC_RX]  = rx_level;
        src_in[SRC_TMO] = rx_timeout_pulse;
        src_in[SRC_OVR] = rx_overrun_pulse;
    end

    assign mask_wr = bus_we && (bus_addr == REG_MASK);
    assign clr_wr  = bus_we && (bus_addr == REG_CLEAR);

    genvar g;
    generate
        for (g = NEVT; g < NSRC; g++) begin : g_level
            sirq_level_stage #(.RST_VAL(RST_BITS[g])) u_lvl (
                .clk   (clk),
                .rst   (rst),
                .lvl_i (src_in[g]),
                .q_o   (raw_q[g])
            );
        end
        for (g = 0; g < NEVT; g++) begin : g_event
            sirq_event_latch u_evt (
                .clk     (clk),
                .rst     (rst),
                .pulse_i (src_in[g]),
                .clr_i   (clr_wr && bus_wdata[g]),
                .q_o     (raw_q[g])
            );
        end
    endgenerate

    sirq_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mask_wr),
        .wdata  (bus_wdata),
        .mask_o (mask_q)
    );

    sirq_readback #(.DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_addr),
        .raw   (raw_q),
        .mask  (mask_q),
        .rdata (bus_rdata)
    );

    assign irq = |gate_sources(raw_q, mask_q);

    // R2: reset values of raw status
    a_r2_raw_reset: assert property (@(posedge clk)
        rst |=> (raw_q == RST_BITS));
    // R8: no interrupt without an enabled source
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0));
    // R9: raw event bits untouched by writes outside the clear register
    a_r9_raw_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == REG_RAW) && !rx_timeout_pulse && !rx_overrun_pulse)
        |=> (raw_q[NEVT-1:0] == $past(raw_q[NEVT-1:0])));
endmodule

// File: tb/sirq_status_unit_bench.sv
module sirq_status_unit_bench;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic       tx;
        logic       rx;
        logic       tmo;
        logic       ovr;
        logic       we;
        logic [1:0] addr;
        logic [3:0] wd;
        logic [1:0] raddr;
        logic [3:0] exp;
        logic       eirq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    // fields: tx rx tmo ovr we addr wd raddr exp irq req
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,4'h0,2'd1,4'h8,1'b0,4'd3},  // R3 tx level
        '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,4'hF,2'd0,4'hF,1'b1,4'd1},  // R1 mask write
        '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,4'h0,2'd1,4'h4,1'b1,4'd3},  // R3 levels swap
        '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,4'h0,2'd1,4'h2,1'b1,4'd4},  // R4 timeout set
        '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'h0,2'd1,4'h2,1'b1,4'd4},  // R4 sticky
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,4'h0,2'd2,4'h3,1'b1,4'd7},  // R7 masked
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,4'h1,2'd1,4'h2,1'b1,4'd5},  // R5 clear ovr
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,4'h0,2'd1,4'h2,1'b1,4'd5},  // R5 zero write
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'd3,4'hC,2'd1,4'hE,1'b1,4'd5},  // R5 level bits
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,4'h2,2'd1,4'h0,1'b0,4'd5},  // R5 clear tmo
        '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd3,4'h2,2'd1,4'h2,1'b1,4'd6},  // R6 event wins
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,4'h1,2'd2,4'h0,1'b0,4'd8},  // R8 masked off
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,4'hF,2'd1,4'h2,1'b0,4'd9},  // R9 raw write
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,4'hF,2'd0,4'h1,1'b0,4'd9},  // R9 masked write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,4'h0,2'd3,4'h0,1'b0,4'd10}, // R10 clear reads 0
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,4'h0,2'd2,4'h1,1'b1,4'd8},  // R8 irq on ovr
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,4'h3,2'd1,4'h0,1'b0,4'd5}   // R5 clear both
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [3:0]        bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_level = 1'b0;
    logic              rx_level = 1'b0;
    logic              rx_timeout_pulse = 1'b0;
    logic              rx_overrun_pulse = 1'b0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sirq_status_unit #(.DATA_W(DATA_W)) u_sirq_status_unit (
        .clk              (clk),
        .rst              (rst),
        .bus_addr         (bus_addr),
        .bus_we           (bus_we),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .tx_level         (tx_level),
        .rx_level         (rx_level),
        .rx_timeout_pulse (rx_timeout_pulse),
        .rx_overrun_pulse (rx_overrun_pulse),
        .irq              (irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [1:0] a, input string req,
                           input logic [DATA_W-1:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 and R1: state right after reset
        read_at(2'd1, "R2 raw reset", 32'h8);
        read_at(2'd0, "R1 mask reset", 32'h0);
        check("R8 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tx_level         = VECS[i].tx;
            rx_level         = VECS[i].rx;
            rx_timeout_pulse = VECS[i].tmo;
            rx_overrun_pulse = VECS[i].ovr;
            bus_we           = VECS[i].we;
            bus_addr         = VECS[i].addr;
            bus_wdata        = VECS[i].wd;
            @(negedge clk);
            bus_we           = 1'b0;
            rx_timeout_pulse = 1'b0;
            rx_overrun_pulse = 1'b0;
            bus_addr         = VECS[i].raddr;
            #1;
            check($sformatf("R%0d vector %0d rdata", VECS[i].req, i),
                  bus_rdata, {28'b0, VECS[i].exp});
            check($sformatf("R8 vector %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].eirq});
        end

        // R2 and R1: reset in mid-operation
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 4'hF;
        rx_overrun_pulse = 1'b1; tx_level = 1'b0; rx_level = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; rx_overrun_pulse = 1'b0;
        read_at(2'd2, "R7 masked before reset", 32'h5);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_at(2'd1, "R2 raw after reset", 32'h8);
        read_at(2'd0, "R1 mask after reset", 32'h0);
        check("R8 irq after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule